// File: doc/BRIEF.md
# Masked Event Alarm Controller

This block collects error and warning events from an encoder counter and turns them into two alarms. Each event sets a sticky pending flag. A per-event enable field decides whether a pending flag pulls its class alarm low. Each alarm is an active-low open-drain pin, modelled here as an output-enable plus a separate readback input. The block also watches its own alarm pins. A low level on a pin that the block is not driving is taken as an external error or warning, and that becomes an event of its own. Any low level at all, whatever its cause, is recorded in a sticky external status bit.

Two status bytes can be read. Reading either one clears every pending flag and both external status bits. The clear takes effect at the clock edge that closes the read cycle. The read data is the value before the clear, and an event that arrives during the read cycle is kept. Status also shows two live signals: the touch-probe input level, and a filtered interface mode-select level. Each change of the filtered mode is itself an event.

Top module: `evt_alarm_ctrl`

## Requirements
- R1: A strobe on src_i[k] sets its pending flag at the next clock edge. The flag holds until a status read, whatever the enable bits. The src_i order is: 0 collision, 1 reference valid, 2 counter overflow, 3 reference overflow, 4 power-down, 5 touch-probe valid, 6 counter zero, 7 update valid, 8 decode error. The collision flag is bit 1 of both status bytes. stat_a_o[7:4] is {counter zero, touch-probe valid, power-down, reference overflow}. stat_b_o[7:4] is {counter overflow, reference valid, decode error, update valid}.
- R2: en_mask_i uses 1 = drive the alarm and 0 = suppress it. The bits, from 9 down to 0, are: mode change, external error, counter zero, touch-probe valid, power-down, reference overflow, counter overflow, reference valid, external warning, collision.
- R3: dis_mask_i uses inverted polarity, with 0 = drive the alarm and 1 = suppress it. Bit 1 is decode error and bit 0 is update valid.
- R4: err_oe_o is 1 exactly when an enabled pending event of the error class exists. The error class is external error and decode error. warn_oe_o is 1 exactly when an enabled pending event of any other class exists. Both outputs follow the pending flags and the enables in the same cycle.
- R5: If a cycle has err_pin_i low while err_oe_o is 0, the external-error event becomes pending. The same rule holds for warn_pin_i and warn_oe_o, which set the external-warning event.
- R6: Bit 3 (external error) and bit 2 (external warning) of both status bytes are sticky. Each sets at the edge after any cycle in which its pin reads low, whether the pin was pulled by an outside device or by the block itself.
- R7: A cycle with rd_a_i or rd_b_i high clears every pending flag and bits 3:2 at its closing edge. Status read in that cycle shows the values before the clear. An event present in that cycle remains set.
- R8: stat_a_o[0] equals the tp_i level at all times, with no latching.
- R9: stat_b_o[0] is the filtered sel_open_i level, where 1 means the select pin is open and the serial-shift mode is chosen. It resets to 0. It takes a new level only after sel_open_i has differed from it for FILT_CYC consecutive cycles.
- R10: Every change of the filtered mode level makes the mode-change event pending.
- R11: After reset, all flags and status bits are 0 and both output-enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 9 | Internal event strobes |
| en_mask_i | input | 10 | Event enables, 1 = alarm enabled |
| dis_mask_i | input | 2 | Event disables, 0 = alarm enabled |
| err_pin_i | input | 1 | Error alarm pin readback |
| warn_pin_i | input | 1 | Warning alarm pin readback |
| tp_i | input | 1 | Touch-probe input level |
| sel_open_i | input | 1 | Raw mode-select level, 1 = pin open |
| rd_a_i | input | 1 | Read strobe for status byte A |
| rd_b_i | input | 1 | Read strobe for status byte B |
| err_oe_o | output | 1 | Error alarm pull-down enable |
| warn_oe_o | output | 1 | Warning alarm pull-down enable |
| stat_a_o | output | 8 | Status byte A |
| stat_b_o | output | 8 | Status byte B |

## Verification
The assertions check several rules on every cycle. Idle alarms follow when nothing is pending. An undriven low pin is captured as an external event. A low pin sets the external status bit. A strobe sets its flag. A quiet read clears the status. A change of the filtered mode must match the raw level. Other behaviour shows only in the bench's scenarios. That includes the mixed mask polarities, the exact filter length, and a same-cycle event surviving a read. It also includes the read-cycle self-capture of the block's own pull-down, which leaves the external bits set after a single read.

// File: rtl/evt_alarm_pkg.sv
package evt_alarm_pkg;
  localparam int N_SRC = 9;
  localparam int N_EV  = 12;
  localparam int N_EN  = 10;

  localparam int EV_COL    = 0;
  localparam int EV_XWARN  = 1;
  localparam int EV_REFV   = 2;
  localparam int EV_CNTOVF = 3;
  localparam int EV_REFOVF = 4;
  localparam int EV_PWRDN  = 5;
  localparam int EV_TPV    = 6;
  localparam int EV_ZERO   = 7;
  localparam int EV_XERR   = 8;
  localparam int EV_MODE   = 9;
  localparam int EV_UPDV   = 10;
  localparam int EV_DECERR = 11;

  typedef logic [N_EV-1:0] ev_vec_t;

  localparam ev_vec_t ERR_CLASS = ev_vec_t'((1 << EV_XERR) | (1 << EV_DECERR));
endpackage

// File: rtl/evt_alarm_filt.sv
module evt_alarm_filt #(
  parameter int FILT_CYC = 1250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o,
  output logic chg_o
);
  localparam int CW = (FILT_CYC > 2) ? $clog2(FILT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          diff;

  assign diff  = raw_i ^ filt_o;
  assign chg_o = diff && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_o <= 1'b0;
    end else if (!diff) begin
      cnt_q <= '0;
    end else if (chg_o) begin
      cnt_q  <= '0;
      filt_o <= raw_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/evt_alarm_sticky.sv
module evt_alarm_sticky #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  // set wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~{W{clr_i}}) | set_i;
  end
endmodule

// File: rtl/evt_alarm_gate.sv
module evt_alarm_gate
  import evt_alarm_pkg::*;
(
  input  ev_vec_t pend_i,
  input  ev_vec_t en_i,
  output logic    err_o,
  output logic    warn_o
);
  ev_vec_t err_hit, warn_hit;

  for (genvar i = 0; i < N_EV; i++) begin : g_cls
    if (ERR_CLASS[i]) begin : g_err
      assign err_hit[i]  = pend_i[i] & en_i[i];
      assign warn_hit[i] = 1'b0;
    end else begin : g_warn
      assign err_hit[i]  = 1'b0;
      assign warn_hit[i] = pend_i[i] & en_i[i];
    end
  end

  assign err_o  = |err_hit;
  assign warn_o = |warn_hit;
endmodule

// File: rtl/evt_alarm_ctrl.sv
module evt_alarm_ctrl
  import evt_alarm_pkg::*;
#(
  parameter int FILT_CYC = 1250
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [N_EN-1:0]   en_mask_i,
  input  logic [1:0]        dis_mask_i,
  input  logic              err_pin_i,
  input  logic              warn_pin_i,
  input  logic              tp_i,
  input  logic              sel_open_i,
  input  logic              rd_a_i,
  input  logic              rd_b_i,
  output logic              err_oe_o,
  output logic              warn_oe_o,
  output logic [7:0]        stat_a_o,
  output logic [7:0]        stat_b_o
);
  ev_vec_t    en, set, pend_q;
  logic [1:0] xst_set, xst_q;  // [1] error pin, [0] warning pin
  logic       mode_q, mode_chg, clr;

  assign clr = rd_a_i | rd_b_i;
  // inverted-polarity fields sit above the positive ones
  assign en  = {~dis_mask_i, en_mask_i};

  evt_alarm_filt #(.FILT_CYC(FILT_CYC)) i_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (sel_open_i),
    .filt_o (mode_q),
    .chg_o  (mode_chg)
  );

  always_comb begin
    set            = '0;
    set[EV_COL]    = src_i[0];
    set[EV_REFV]   = src_i[1];
    set[EV_CNTOVF] = src_i[2];
    set[EV_REFOVF] = src_i[3];
    set[EV_PWRDN]  = src_i[4];
    set[EV_TPV]    = src_i[5];
    set[EV_ZERO]   = src_i[6];
    set[EV_UPDV]   = src_i[7];
    set[EV_DECERR] = src_i[8];
    set[EV_MODE]   = mode_chg;
    // pin low while not driving it: someone else pulls
    set[EV_XERR]   = ~err_pin_i & ~err_oe_o;
    set[EV_XWARN]  = ~warn_pin_i & ~warn_oe_o;
  end

  assign xst_set = {~err_pin_i, ~warn_pin_i};

  evt_alarm_sticky #(.W(N_EV)) i_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set),
    .clr_i  (clr),
    .q_o    (pend_q)
  );

  evt_alarm_sticky #(.W(2)) i_xst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (xst_set),
    .clr_i  (clr),
    .q_o    (xst_q)
  );

  evt_alarm_gate i_gate (
    .pend_i (pend_q),
    .en_i   (en),
    .err_o  (err_oe_o),
    .warn_o (warn_oe_o)
  );

  assign stat_a_o = {pend_q[EV_ZERO], pend_q[EV_TPV], pend_q[EV_PWRDN], pend_q[EV_REFOVF],
                     xst_q, pend_q[EV_COL], tp_i};
  assign stat_b_o = {pend_q[EV_CNTOVF], pend_q[EV_REFV], pend_q[EV_DECERR], pend_q[EV_UPDV],
                     xst_q, pend_q[EV_COL], mode_q};
endmodule

// File: rtl/evt_alarm_chk.sv
module evt_alarm_chk
  import evt_alarm_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] src_i,
  input logic             err_pin_i,
  input logic             warn_pin_i,
  input logic             sel_open_i,
  input logic             rd_a_i,
  input logic             rd_b_i,
  input logic             err_oe_o,
  input logic             warn_oe_o,
  input logic [7:0]       stat_a_o,
  input logic [7:0]       stat_b_o,
  input ev_vec_t          pend_i
);
  // R4
  idle_no_alarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i == '0) |-> (!err_oe_o && !warn_oe_o));

  // R5
  ext_err_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_pin_i && !err_oe_o) |=> pend_i[EV_XERR]);

  // R6
  ext_err_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_pin_i |=> (stat_a_o[3] && stat_b_o[3]));

  // R1
  col_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_i[0] |=> (stat_a_o[1] && stat_b_o[1]));

  // R7
  quiet_read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_a_i || rd_b_i) && src_i == '0 && err_pin_i && warn_pin_i)
      |=> (stat_a_o[7:1] == 7'd0 && stat_b_o[7:1] == 7'd0));

  // R9
  mode_follows_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(stat_b_o[0]) |-> (stat_b_o[0] == $past(sel_open_i)));
endmodule

bind evt_alarm_ctrl evt_alarm_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_i      (src_i),
  .err_pin_i  (err_pin_i),
  .warn_pin_i (warn_pin_i),
  .sel_open_i (sel_open_i),
  .rd_a_i     (rd_a_i),
  .rd_b_i     (rd_b_i),
  .err_oe_o   (err_oe_o),
  .warn_oe_o  (warn_oe_o),
  .stat_a_o   (stat_a_o),
  .stat_b_o   (stat_b_o),
  .pend_i     (pend_q)
);

// File: tb/test_evt_alarm_ctrl.sv
`timescale 1ns/1ps
module test_evt_alarm_ctrl;
  localparam int F = 16;
  localparam logic [11:0] ERRC = 12'h900;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [8:0] src = '0;
  logic [9:0] en_mask = '0;
  logic [1:0] dis_mask = '0;
  logic       pull_err = 1'b0, pull_warn = 1'b0, tp = 1'b0, sel = 1'b0, rd_a = 1'b0, rd_b = 1'b0;
  logic       err_oe, warn_oe, err_pin, warn_pin;
  logic [7:0] stat_a, stat_b;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [11:0] m_pend = '0;
  logic [1:0]  m_sx = '0;
  logic        m_mode = 1'b0;
  int          m_fcnt = 0;

  always #5 clk = ~clk;

  assign err_pin  = ~(err_oe | pull_err);
  assign warn_pin = ~(warn_oe | pull_warn);

  evt_alarm_ctrl #(.FILT_CYC(F)) i_evt_alarm_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .en_mask_i(en_mask), .dis_mask_i(dis_mask),
    .err_pin_i(err_pin), .warn_pin_i(warn_pin), .tp_i(tp), .sel_open_i(sel),
    .rd_a_i(rd_a), .rd_b_i(rd_b), .err_oe_o(err_oe), .warn_oe_o(warn_oe),
    .stat_a_o(stat_a), .stat_b_o(stat_b)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] m_en();
    return {~dis_mask, en_mask};
  endfunction
  function automatic logic m_eoe();
    return |(m_pend & m_en() & ERRC);
  endfunction
  function automatic logic m_woe();
    return |(m_pend & m_en() & ~ERRC);
  endfunction
  function automatic logic [7:0] m_sa();
    return {m_pend[7], m_pend[6], m_pend[5], m_pend[4], m_sx, m_pend[0], tp};
  endfunction
  function automatic logic [7:0] m_sb();
    return {m_pend[3], m_pend[2], m_pend[11], m_pend[10], m_sx, m_pend[0], m_mode};
  endfunction

  task automatic compare();
    chk(err_oe == m_eoe(), "R4 error alarm", {7'd0, err_oe}, {7'd0, m_eoe()});
    chk(warn_oe == m_woe(), "R4 warning alarm", {7'd0, warn_oe}, {7'd0, m_woe()});
    chk(stat_a == m_sa(), "R1/R6/R7/R8 status A", stat_a, m_sa());
    chk(stat_b == m_sb(), "R1/R6/R7/R9 status B", stat_b, m_sb());
  endtask

  // one clock: model next state from present inputs, then compare after the edge
  task automatic step();
    logic [11:0] set_v, pend_n;
    logic [1:0]  sx_n;
    logic        eoe, woe, chg, mode_n, clr;
    int          fcnt_n;
    eoe = m_eoe(); woe = m_woe(); clr = rd_a | rd_b;
    chg = 1'b0; mode_n = m_mode; fcnt_n = 0;
    if (sel != m_mode) begin
      if (m_fcnt == F - 1) begin chg = 1'b1; mode_n = sel; end
      else fcnt_n = m_fcnt + 1;
    end
    set_v = {src[8], src[7], chg, pull_err & ~eoe, src[6], src[5], src[4], src[3],
             src[2], src[1], pull_warn & ~woe, src[0]};
    pend_n = (clr ? 12'd0 : m_pend) | set_v;
    sx_n   = (clr ? 2'd0 : m_sx) | {eoe | pull_err, woe | pull_warn};
    @(posedge clk);
    m_pend = pend_n; m_sx = sx_n; m_mode = mode_n; m_fcnt = fcnt_n;
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20241));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state
    chk(stat_a == 8'h00 && stat_b == 8'h00, "R11 reset status", stat_a, 8'h00);
    chk(!err_oe && !warn_oe, "R11 reset alarms", {6'd0, err_oe, warn_oe}, 8'h00);

    // R1 R2 R3: all suppressed, every strobe latched
    dis_mask = 2'b11; src = 9'h1FF;
    step(); src = '0;
    chk(stat_a == 8'hF2, "R1 latch A", stat_a, 8'hF2);
    chk(stat_b == 8'hF2, "R1 latch B", stat_b, 8'hF2);
    chk(!err_oe && !warn_oe, "R2 R3 suppressed", {6'd0, err_oe, warn_oe}, 8'h00);
    en_mask = 10'h008; step();
    chk(warn_oe && !err_oe, "R2 counter overflow enable", {6'd0, err_oe, warn_oe}, 8'h01);
    dis_mask = 2'b01; step();
    chk(err_oe == 1'b1, "R3 decode error enabled by 0", {7'd0, err_oe}, 8'h01);
    chk(stat_a[3] && stat_a[2], "R6 own drive recorded", stat_a, 8'h0C);

    // R7: read clears, own pull-down in the read cycle is kept
    rd_a = 1'b1; step(); rd_a = 1'b0;
    chk(stat_a == 8'h0C, "R7 read clears pending", stat_a, 8'h0C);
    chk(!err_oe && !warn_oe, "R7 alarms released", {6'd0, err_oe, warn_oe}, 8'h00);
    step();
    rd_b = 1'b1; step();
    chk(stat_a == 8'h00 && stat_b == 8'h00, "R7 second read", stat_a, 8'h00);
    src = 9'h020; step(); src = '0; rd_b = 1'b0;
    chk(stat_a == 8'h40, "R7 event in read cycle kept", stat_a, 8'h40);
    rd_a = 1'b1; step(); rd_a = 1'b0;

    // R5: outside pull-down on the error pin
    en_mask = 10'h100; dis_mask = 2'b11;
    pull_err = 1'b1; step();
    chk(err_oe && stat_a[3], "R5 external error captured", {7'd0, err_oe}, 8'h01);
    pull_err = 1'b0; step();
    chk(err_oe == 1'b1, "R5 external error sticky", {7'd0, err_oe}, 8'h01);
    rd_a = 1'b1; step();
    chk(!err_oe && stat_a == 8'h08, "R5 R7 cleared, no self-trigger", stat_a, 8'h08);
    step(); rd_a = 1'b0;
    chk(stat_a == 8'h00, "R7 idle after reads", stat_a, 8'h00);

    // R8
    tp = 1'b1; #1;
    chk(stat_a == 8'h01, "R8 touch-probe level", stat_a, 8'h01);
    tp = 1'b0; #1;
    chk(stat_a == 8'h00, "R8 touch-probe low", stat_a, 8'h00);

    // R9 R10: filter length and mode-change event
    en_mask = 10'h200; sel = 1'b1;
    repeat (F - 1) step();
    chk(stat_b[0] == 1'b0, "R9 not yet stable", stat_b, 8'h00);
    step();
    chk(stat_b[0] == 1'b1, "R9 filtered after full count", stat_b, 8'h01);
    chk(warn_oe == 1'b1, "R10 mode change alarm", {7'd0, warn_oe}, 8'h01);
    rd_b = 1'b1; step(); step(); rd_b = 1'b0;
    sel = 1'b0; repeat (F - 1) step(); sel = 1'b1; step();
    chk(stat_b[0] == 1'b1, "R9 short glitch rejected", stat_b, 8'h01);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      if (i % 100 == 0) begin
        en_mask = 10'($urandom); dis_mask = 2'($urandom);
      end
      for (int b = 0; b < 9; b++) src[b] = ($urandom % 20 == 0);
      rd_a = ($urandom % 7 == 0);
      rd_b = ($urandom % 9 == 0);
      pull_err  = ($urandom % 15 == 0);
      pull_warn = ($urandom % 15 == 0);
      if ($urandom % 4 == 0) tp = ~tp;
      if ($urandom % 40 == 0) sel = ~sel;
      step();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule